// File: doc/BRIEF.md
# Receive and Transmit Frame Timestamp Trailer Unit

This block watches two byte-wide MII-side streams, one for receive and one for transmit. Each beat carries a data byte with a valid strobe and a last marker on the final byte of the frame. In each frame the unit looks for the start-of-frame delimiter byte (0xD5) that ends the preamble. On the beat where the delimiter appears, it takes a copy of the running wallclock. The wallclock is 48 bits of seconds and 32 bits of nanoseconds.

On the receive side, every byte passes through one register stage. When software timestamping is switched on, the unit adds a fixed 5-byte trailer after the final byte of the frame, which is the last byte of the FCS. The trailer is one byte of seconds followed by four bytes of nanoseconds. The extended frame then goes on to the host packet buffer.

On the transmit side, the stream is only observed. The copied time is held in host-readable registers with a sticky valid flag and an overrun flag. The host clears both flags with a one-cycle pulse.

Top module: `eth_ts_trailer`

## Requirements
- R1: Every receive input beat appears on the receive output exactly one clock later, with the same byte value. When no trailer is added, the last marker also comes out unchanged.
- R2: The capture point is the first 0xD5 byte of a frame. A 0xD5 that appears later in the same frame causes no new capture, on either side.
- R3: The trailer is one byte of seconds, then the nanoseconds least-significant byte first. The seconds byte is the low 8 bits of the captured seconds. The trailer follows the final input byte, so it sits behind the FCS.
- R4: The five trailer bytes leave on five consecutive valid beats, starting on the beat right after the final input byte. The last marker is removed from the final input byte and is raised only on the fifth trailer byte.
- R5: A frame whose last marker arrives before any 0xD5 byte gets no trailer and produces no transmit capture. The next frame starts hunting for the delimiter afresh.
- R6: The trailer is added only if the mode input `sw_ts_en` is 1 on the delimiter beat. Changing the mode later in the frame has no effect on that frame. With the mode off, the frame leaves the block unchanged.
- R7: A delimiter on the transmit stream loads all 48 seconds bits and all 32 nanoseconds bits into the timestamp registers. The valid flag reads 1 from the following clock onward.
- R8: While the valid flag is set, a later transmit delimiter leaves the held time unchanged and sets the sticky overrun flag.
- R9: A clear pulse drops the valid and overrun flags on the next clock. If the clear pulse and a delimiter arrive on the same beat, the new time is loaded, valid stays 1 and overrun reads 0.
- R10: After reset, the receive output is idle and both transmit flags read 0.
- R11: After a frame that takes a trailer, the receive input must stay idle for at least 5 beats. Ethernet's interframe gap guarantees this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both streams |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_ts_en | input | 1 | Software timestamping mode; 1 adds receive trailers |
| wc_sec | input | 48 | Wallclock seconds |
| wc_ns | input | 32 | Wallclock nanoseconds |
| rx_in_data | input | 8 | Receive byte from the MII side |
| rx_in_valid | input | 1 | Receive byte strobe |
| rx_in_last | input | 1 | Final byte of the receive frame |
| rx_out_data | output | 8 | Receive byte toward the packet buffer |
| rx_out_valid | output | 1 | Output byte strobe |
| rx_out_last | output | 1 | Final byte of the extended frame |
| tx_in_data | input | 8 | Transmit byte observed on the MII side |
| tx_in_valid | input | 1 | Transmit byte strobe |
| tx_in_last | input | 1 | Final byte of the transmit frame |
| tx_ts_clear | input | 1 | Host pulse clearing the valid and overrun flags |
| tx_ts_sec | output | 48 | Captured transmit seconds |
| tx_ts_ns | output | 32 | Captured transmit nanoseconds |
| tx_ts_valid | output | 1 | Sticky flag showing a capture is held |
| tx_ts_overrun | output | 1 | Sticky flag showing a capture was refused |

## Verification
The sweep runs every preamble length from 0 to 7 and payload lengths of 0, 1, 3 and 46 bytes, each with the mode both on and off. Varying the preamble length places the delimiter in a different clock cycle on each run. Since the wallclock changes every cycle, a trailer or register value taken one beat early or late shows up as a wrong value. Payloads of 3 bytes or more carry a second 0xD5, which would expose a capture that re-arms within the frame. Further cases cover frames made only of preamble, a mode change just after the delimiter, back-to-back transmit captures without a clear, and a clear pulse on the same beat as a delimiter; these separate the no-delimiter rule, the sampling point of the mode, and the overrun and clear priorities.

// File: rtl/eth_ts_pkg.sv
package eth_ts_pkg;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef enum logic {
        ST_PASS  = 1'b0,
        ST_TRAIL = 1'b1
    } rx_mode_t;
endpackage

// File: rtl/eth_ts_sfd_detect.sv
module eth_ts_sfd_detect
    import eth_ts_pkg::*;
#(
    parameter logic [7:0] DELIM = SFD_BYTE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       sfd_hit
);
    typedef struct packed {
        logic hunting;
    } det_state_t;

    det_state_t q, d;

    always_comb begin
        d       = q;
        sfd_hit = in_valid && q.hunting && (in_data == DELIM);
        if (in_valid) begin
            if (in_last) begin
                d.hunting = 1'b1;
            end else if (sfd_hit) begin
                d.hunting = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hunting <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_HUNT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> q.hunting); // R5
    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sfd_hit && !in_last) |=> !sfd_hit); // R2
endmodule

// File: rtl/eth_ts_rx_append.sv
module eth_ts_rx_append
    import eth_ts_pkg::*;
#(
    parameter int NS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_en,
    input  logic [7:0]      sec_lo,
    input  logic [NS_W-1:0] wc_ns,
    input  logic [7:0]      in_data,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic            sfd_hit,
    output logic [7:0]      out_data,
    output logic            out_valid,
    output logic            out_last
);
    localparam int TRAIL_LEN = 1 + NS_W / 8;
    localparam int TRAIL_W   = 8 * TRAIL_LEN;
    localparam int CNT_W     = $clog2(TRAIL_LEN);

    typedef struct packed {
        rx_mode_t           st;
        logic [CNT_W-1:0]   idx;
        logic               seen;
        logic               en;
        logic [TRAIL_W-1:0] trail;
        logic [7:0]         out_data;
        logic               out_valid;
        logic               out_last;
    } app_state_t;

    app_state_t q, d;
    logic       app_seen;
    logic       app_en;

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.out_last  = 1'b0;
        app_seen    = q.seen || sfd_hit;
        app_en      = sfd_hit ? mode_en : q.en;
        if (sfd_hit) begin
            d.seen  = 1'b1;
            d.en    = mode_en;
            d.trail = {wc_ns, sec_lo};
        end
        case (q.st)
            ST_PASS: begin
                if (in_valid) begin
                    d.out_data  = in_data;
                    d.out_valid = 1'b1;
                    if (in_last) begin
                        d.seen = 1'b0;
                        if (app_seen && app_en) begin
                            d.st  = ST_TRAIL;
                            d.idx = '0;
                        end else begin
                            d.out_last = 1'b1;
                        end
                    end
                end
            end
            default: begin
                d.out_valid = 1'b1;
                d.out_data  = q.trail[7:0];
                d.trail     = q.trail >> 8;
                d.idx       = q.idx + 1'b1;
                if (q.idx == CNT_W'(TRAIL_LEN - 1)) begin
                    d.out_last = 1'b1;
                    d.st       = ST_PASS;
                    d.idx      = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_data  = q.out_data;
    assign out_valid = q.out_valid;
    assign out_last  = q.out_last;

    AST_NO_INPUT_IN_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TRAIL) |-> !in_valid); // R11
    AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PASS && in_valid) |=> (out_valid && out_data == $past(in_data))); // R1
    AST_TRAIL_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TRAIL && !(q.idx == CNT_W'(TRAIL_LEN - 1))) |=> (out_valid && !out_last)); // R4
endmodule

// File: rtl/eth_ts_tx_capture.sv
module eth_ts_tx_capture #(
    parameter int SEC_W = 48,
    parameter int NS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] wc_sec,
    input  logic [NS_W-1:0]  wc_ns,
    input  logic             sfd_hit,
    input  logic             clear,
    output logic [SEC_W-1:0] ts_sec,
    output logic [NS_W-1:0]  ts_ns,
    output logic             ts_valid,
    output logic             ts_overrun
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic             valid;
        logic             overrun;
    } cap_state_t;

    cap_state_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.valid   = 1'b0;
            d.overrun = 1'b0;
        end
        if (sfd_hit) begin
            if (!q.valid || clear) begin
                d.sec   = wc_sec;
                d.ns    = wc_ns;
                d.valid = 1'b1;
            end else begin
                d.overrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ts_sec     = q.sec;
    assign ts_ns      = q.ns;
    assign ts_valid   = q.valid;
    assign ts_overrun = q.overrun;

    AST_OVERRUN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ts_overrun |-> ts_valid); // R8
    AST_HELD_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !clear) |=> ($stable(ts_sec) && $stable(ts_ns))); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !sfd_hit) |=> (!ts_valid && !ts_overrun)); // R9
    AST_VALID_FROM_SFD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts_valid) |-> $past(sfd_hit)); // R7
endmodule

// File: rtl/eth_ts_trailer.sv
module eth_ts_trailer
    import eth_ts_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_ts_en,
    input  logic [SEC_W-1:0] wc_sec,
    input  logic [NS_W-1:0]  wc_ns,
    input  logic [7:0]       rx_in_data,
    input  logic             rx_in_valid,
    input  logic             rx_in_last,
    output logic [7:0]       rx_out_data,
    output logic             rx_out_valid,
    output logic             rx_out_last,
    input  logic [7:0]       tx_in_data,
    input  logic             tx_in_valid,
    input  logic             tx_in_last,
    input  logic             tx_ts_clear,
    output logic [SEC_W-1:0] tx_ts_sec,
    output logic [NS_W-1:0]  tx_ts_ns,
    output logic             tx_ts_valid,
    output logic             tx_ts_overrun
);
    localparam int LANES = 2;

    logic [7:0] lane_data  [LANES];
    logic       lane_valid [LANES];
    logic       lane_last  [LANES];
    logic       lane_hit   [LANES];

    assign lane_data[0]  = rx_in_data;
    assign lane_valid[0] = rx_in_valid;
    assign lane_last[0]  = rx_in_last;
    assign lane_data[1]  = tx_in_data;
    assign lane_valid[1] = tx_in_valid;
    assign lane_last[1]  = tx_in_last;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        eth_ts_sfd_detect #(.DELIM(SFD_BYTE)) i_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_data  (lane_data[g]),
            .in_valid (lane_valid[g]),
            .in_last  (lane_last[g]),
            .sfd_hit  (lane_hit[g])
        );
    end

    eth_ts_rx_append #(.NS_W(NS_W)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (sw_ts_en),
        .sec_lo    (wc_sec[7:0]),
        .wc_ns     (wc_ns),
        .in_data   (rx_in_data),
        .in_valid  (rx_in_valid),
        .in_last   (rx_in_last),
        .sfd_hit   (lane_hit[0]),
        .out_data  (rx_out_data),
        .out_valid (rx_out_valid),
        .out_last  (rx_out_last)
    );

    eth_ts_tx_capture #(.SEC_W(SEC_W), .NS_W(NS_W)) i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wc_sec     (wc_sec),
        .wc_ns      (wc_ns),
        .sfd_hit    (lane_hit[1]),
        .clear      (tx_ts_clear),
        .ts_sec     (tx_ts_sec),
        .ts_ns      (tx_ts_ns),
        .ts_valid   (tx_ts_valid),
        .ts_overrun (tx_ts_overrun)
    );
endmodule

// File: tb/test_eth_ts_trailer.sv
module test_eth_ts_trailer;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_ts_en = 1'b0;
    logic [47:0] wc_sec;
    logic [31:0] wc_ns;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        tx_ts_clear = 1'b0;
    logic [7:0]  rx_out_data;
    logic        rx_out_valid, rx_out_last;
    logic [47:0] tx_ts_sec;
    logic [31:0] tx_ts_ns;
    logic        tx_ts_valid, tx_ts_overrun;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [47:0] fsec(int c);
        return 48'h0012_3400_0000 + 48'(c) * 48'd7;
    endfunction
    function automatic logic [31:0] fns(int c);
        return 32'(c) * 32'h0103_0507 + 32'h11;
    endfunction
    assign wc_sec = fsec(cyc);
    assign wc_ns  = fns(cyc);

    eth_ts_trailer i_eth_ts_trailer (
        .clk(clk), .rst_n(rst_n), .sw_ts_en(sw_ts_en),
        .wc_sec(wc_sec), .wc_ns(wc_ns),
        .rx_in_data(in_data), .rx_in_valid(in_valid), .rx_in_last(in_last),
        .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid), .rx_out_last(rx_out_last),
        .tx_in_data(in_data), .tx_in_valid(in_valid), .tx_in_last(in_last),
        .tx_ts_clear(tx_ts_clear),
        .tx_ts_sec(tx_ts_sec), .tx_ts_ns(tx_ts_ns),
        .tx_ts_valid(tx_ts_valid), .tx_ts_overrun(tx_ts_overrun)
    );

    logic [7:0] obs_d [MAXB];
    logic       obs_l [MAXB];
    int         obs_n = 0;

    always @(negedge clk) begin
        if (rx_out_valid && obs_n < MAXB) begin
            obs_d[obs_n] = rx_out_data;
            obs_l[obs_n] = rx_out_last;
            obs_n = obs_n + 1;
        end
    end

    logic        m_valid = 1'b0;
    logic        m_ovr = 1'b0;
    logic [47:0] m_sec = '0;
    logic [31:0] m_ns = '0;

    task automatic chk(bit ok, string req, logic [79:0] act, logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(int pre, int pay, bit with_sfd, bit en, bit flip,
                            bit clr_at_sfd, bit clr_after, string req);
        logic [7:0] fb [MAXB];
        logic [7:0] ex [MAXB];
        int n = 0;
        int ne;
        int sfd_idx = -1;
        int sfd_cyc = 0;
        bit trail;
        bit content_ok = 1'b1;
        for (int i = 0; i < pre; i++) begin fb[n] = 8'h55; n++; end
        if (with_sfd) begin sfd_idx = n; fb[n] = 8'hD5; n++; end
        for (int j = 0; j < pay; j++) begin
            fb[n] = (j == 2) ? 8'hD5 : 8'(8'h30 + j); n++;
        end
        if (with_sfd) for (int k = 0; k < 4; k++) begin fb[n] = 8'(8'hF0 + k); n++; end
        obs_n = 0;
        sw_ts_en = en;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_data = fb[i];
            in_valid = 1'b1;
            in_last = (i == n - 1);
            tx_ts_clear = (i == sfd_idx) ? clr_at_sfd : 1'b0;
            if (i == sfd_idx) sfd_cyc = cyc;
            if (flip && i == sfd_idx + 1) sw_ts_en = !en;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; tx_ts_clear = 1'b0;
        repeat (8) @(negedge clk);
        trail = with_sfd && en;
        for (int i = 0; i < n; i++) ex[i] = fb[i];
        ne = n;
        if (trail) begin
            logic [39:0] t;
            t = {fns(sfd_cyc), fsec(sfd_cyc)[7:0]};
            for (int k = 0; k < 5; k++) begin ex[ne] = t[8*k +: 8]; ne++; end
        end
        chk(obs_n == ne, {req, " R1 R3 R5 R6 length"}, 80'(obs_n), 80'(ne));
        if (obs_n == ne) begin
            for (int i = 0; i < ne; i++) begin
                if (obs_d[i] !== ex[i] || obs_l[i] !== (i == ne - 1)) begin
                    if (content_ok)
                        $display("FAIL %s R3 R4 byte %0d actual=%0h/%0b expected=%0h/%0b",
                                 req, i, obs_d[i], obs_l[i], ex[i], (i == ne - 1));
                    content_ok = 1'b0;
                end
            end
            n_chk++;
            if (!content_ok) n_bad++;
        end
        if (with_sfd) begin
            if (!m_valid || clr_at_sfd) begin
                m_sec = fsec(sfd_cyc); m_ns = fns(sfd_cyc); m_valid = 1'b1; m_ovr = 1'b0;
            end else begin
                m_ovr = 1'b1;
            end
        end
        chk({tx_ts_valid, tx_ts_overrun} === {m_valid, m_ovr}, {req, " R7 R8 R9 flags"},
            80'({tx_ts_valid, tx_ts_overrun}), 80'({m_valid, m_ovr}));
        if (m_valid)
            chk({tx_ts_sec, tx_ts_ns} === {m_sec, m_ns}, {req, " R2 R7 R8 time"},
                {tx_ts_sec, tx_ts_ns}, {m_sec, m_ns});
        if (clr_after) begin
            @(negedge clk); tx_ts_clear = 1'b1;
            @(negedge clk); tx_ts_clear = 1'b0;
            m_valid = 1'b0; m_ovr = 1'b0;
            chk({tx_ts_valid, tx_ts_overrun} === 2'b00, "R9 clear", 80'({tx_ts_valid, tx_ts_overrun}), 80'(0));
        end
    endtask

    initial begin
        int pays [4] = '{0, 1, 3, 46};
        repeat (3) @(negedge clk);
        chk({rx_out_valid, rx_out_last, tx_ts_valid, tx_ts_overrun} === 4'b0000, "R10 reset",
            80'({rx_out_valid, rx_out_last, tx_ts_valid, tx_ts_overrun}), 80'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({rx_out_valid, tx_ts_valid} === 2'b00, "R10 after release",
            80'({rx_out_valid, tx_ts_valid}), 80'(0));
        for (int e = 0; e < 2; e++)
            for (int p = 0; p < 8; p++)
                for (int q = 0; q < 4; q++)
                    run_case(p, pays[q], 1'b1, e[0], 1'b0, 1'b0, 1'b1, "sweep R2 R11");
        for (int p = 1; p < 7; p++)
            run_case(p, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "no delimiter R5");
        run_case(3, 5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "mode flip on R6");
        run_case(3, 5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "mode flip off R6");
        run_case(2, 4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "first capture R7");
        run_case(4, 6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "overrun R8");
        run_case(1, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "overrun again R8");
        run_case(5, 2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "clear with delimiter R9");
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule